// File: doc/BRIEF.md
# Multi-Channel Event Timer

This block is a register-mapped event timer. A free-running main counter (64 bits by default) advances by one on every clock while the global run bit is set. Several comparator channels watch the low 32 bits of that counter. Each channel raises a status bit when the counter equals its comparator. In one-shot mode a channel fires once. In periodic mode it reloads by adding a stored period after every match.

Software reaches the block through a plain 32-bit register port: a write strobe, a read strobe, a 12-bit byte address, and read data that is registered one cycle after the read strobe. The counter can be loaded only while it is halted. A periodic channel is set up with a write sequence: setting the value-arm bit makes the next comparator write the first target and the write after that the period. A legacy routing bit in the global configuration moves channel 0 onto a dedicated interval-timer line and channel 1 onto a dedicated clock-alarm line.

Top module: `evt_timer`

## Requirements
- R1: After reset, the counter reads 0, the global configuration reads 0, the status register reads 0, and every interrupt output is low.
- R2: The capability word at 0x000 holds:
  - bits [7:0]: the revision.
  - bits [12:8]: the channel count minus one.
  - bit 13: set when the counter is 64 bits wide.
  - bit 15: set when legacy routing is available.
  The period word at 0x004 returns the tick period in femtoseconds. The build is rejected when this period lies outside 100,000 to 100,000,000.
- R3: The counter halves sit at 0x0F0 (low) and 0x0F4 (high). While bit 0 of the global configuration word (0x010) is 0, the counter holds and both halves are writable. While that bit is 1, the counter counts up by one per clock, carries from the low half into the high half, and ignores writes to its halves.
- R4: In one-shot mode, channel n sets status bit n on the first clock edge at which the low counter half equals its comparator (0x108+0x20·n), and it does not fire again afterwards.
- R5: A one-shot target that is already behind the counter does not fire.
- R6: A channel configuration word (0x100+0x20·n) written with bit 3 (periodic) and bit 6 (value-arm) set starts a sequence. The next comparator write loads the target and the following one loads the period. Each match then advances the comparator by the period.
- R7: Bit 6 of a channel configuration reads 1 while the arm sequence is pending and 0 once the period write has been taken.
- R8: Channel 1 has no periodic support. Its bits 3 and 6 read 0 whatever is written, and bit 4 (periodic capable) reads 0 for channel 1 and 1 for every other channel.
- R9: Bit 2 of a channel configuration gates that channel's interrupt output only. Matches still set the status bit while the gate is closed, and opening the gate later raises the output.
- R10: The status register at 0x020 is write-1-to-clear. An interrupt output stays high until its status bit is cleared.
- R11: While bit 1 of the global configuration is set, channel 0 drives the interval-timer line and channel 1 drives the clock-alarm line, and `irq_ch[1:0]` stay low.
- R12: Channel configuration bits [13:9] read the fixed route number ROUTE_BASE+n (20+n by default), and bit 5 (32-bit comparator) reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter ticks on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_ch | output | NUM_CH | Per-channel level interrupt |
| irq_legacy_tmr | output | 1 | Interval-timer line while legacy routing is on |
| irq_legacy_rtc | output | 1 | Clock-alarm line while legacy routing is on |

## Verification
The bench targets the following corner cases:
- **Exact match edge.** Random one-shot targets are placed at random counter bases. The bench checks that the interrupt is still low one cycle before the predicted edge and high on it. An off-by-one compare or a registered match would show up here.
- **Counter carry.** The counter is started just below a 32-bit carry and must land on the exact 64-bit value. Writes made while the counter runs must leave no trace.
- **Periodic arm sequence.** The bench checks the reload time and the advanced comparator value. A sequencer that swapped the target and period writes, or never cleared the arm bit, fails on both the comparator readback and the second interrupt time.
- **Gating, clearing and routing.**
  - A match behind a closed gate must still show in status.
  - A status clear must drop the level.
  - A stale past target must stay silent.
  - Legacy routing must mask `irq_ch[1:0]` while the legacy lines fire.

// File: rtl/evt_pkg.sv
`timescale 1ns/1ps
package evt_pkg;
   localparam int ADDR_W = 12;
   localparam int DATA_W = 32;

   localparam logic [11:0] A_CAP    = 12'h000;
   localparam logic [11:0] A_PERIOD = 12'h004;
   localparam logic [11:0] A_GCFG   = 12'h010;
   localparam logic [11:0] A_STATUS = 12'h020;
   localparam logic [11:0] A_CNT_LO = 12'h0F0;
   localparam logic [11:0] A_CNT_HI = 12'h0F4;

   localparam int CH_BASE    = 256;
   localparam int CH_STRIDE  = 32;
   localparam int CH_CFG_OFS = 0;
   localparam int CH_CMP_OFS = 8;

   // global configuration bits
   localparam int G_RUN = 0;
   localparam int G_LEG = 1;

   // channel configuration bits
   localparam int C_INTEN     = 2;
   localparam int C_PER       = 3;
   localparam int C_PCAP      = 4;
   localparam int C_F32       = 5;
   localparam int C_VSET      = 6;
   localparam int C_ROUTE_LSB = 9;
   localparam int ROUTE_W     = 5;

   // capability bits
   localparam int CAP_NCH_LSB = 8;
   localparam int CAP_W64     = 13;
   localparam int CAP_LEG     = 15;

   localparam logic [31:0] MIN_PERIOD_FS = 32'd100_000;
   localparam logic [31:0] MAX_PERIOD_FS = 32'd100_000_000;

   typedef enum logic [1:0] {
      VS_IDLE     = 2'd0,
      VS_WANT_CMP = 2'd1,
      VS_WANT_PER = 2'd2
   } vset_e;

   function automatic logic [11:0] ch_cfg_addr(input int n);
      return 12'(CH_BASE + CH_STRIDE * n + CH_CFG_OFS);
   endfunction

   function automatic logic [11:0] ch_cmp_addr(input int n);
      return 12'(CH_BASE + CH_STRIDE * n + CH_CMP_OFS);
   endfunction
endpackage

// File: rtl/evt_counter.sv
`timescale 1ns/1ps
module evt_counter #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [31:0]      wdata,
   output logic [CNT_W-1:0] cnt
);
   localparam int HI_W = CNT_W - 32;

   logic [CNT_W-1:0] cnt_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_r <= '0;
      end else if (run) begin
         cnt_r <= cnt_r + 1'b1;
      end else if (wr_lo) begin
         cnt_r[31:0] <= wdata;
      end else if (wr_hi) begin
         cnt_r[CNT_W-1:32] <= wdata[HI_W-1:0];
      end
   end

   assign cnt = cnt_r;
endmodule

// File: rtl/evt_channel.sv
`timescale 1ns/1ps
module evt_channel
   import evt_pkg::*;
#(
   parameter bit                 PERIODIC_OK = 1'b1,
   parameter logic [ROUTE_W-1:0] ROUTE       = '0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        run,
   input  logic        cfg_we,
   input  logic        cmp_we,
   input  logic [31:0] wdata,
   input  logic [31:0] cnt_lo,
   output logic [31:0] cfg_rd,
   output logic [31:0] cmp_rd,
   output logic        match,
   output logic        int_en
);
   logic        int_en_q;
   logic        per_q;
   vset_e       vs_q;
   logic [31:0] cmp_q;
   logic [31:0] period_q;

   assign match = run && (cnt_lo == cmp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_en_q <= 1'b0;
         per_q    <= 1'b0;
         vs_q     <= VS_IDLE;
      end else if (cfg_we) begin
         int_en_q <= wdata[C_INTEN];
         per_q    <= PERIODIC_OK ? wdata[C_PER] : 1'b0;
         if (PERIODIC_OK && wdata[C_VSET]) begin
            vs_q <= VS_WANT_CMP;
         end
      end else if (cmp_we && vs_q == VS_WANT_CMP) begin
         vs_q <= VS_WANT_PER;
      end else if (cmp_we && vs_q == VS_WANT_PER) begin
         vs_q <= VS_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q    <= '0;
         period_q <= '0;
      end else if (cmp_we) begin
         if (vs_q == VS_WANT_PER) begin
            period_q <= wdata;
         end else begin
            cmp_q <= wdata;
         end
      end else if (match && per_q) begin
         cmp_q <= cmp_q + period_q;
      end
   end

   always_comb begin
      cfg_rd                                = '0;
      cfg_rd[C_INTEN]                       = int_en_q;
      cfg_rd[C_PER]                         = per_q;
      cfg_rd[C_PCAP]                        = PERIODIC_OK;
      cfg_rd[C_F32]                         = 1'b1;
      cfg_rd[C_VSET]                        = (vs_q != VS_IDLE);
      cfg_rd[C_ROUTE_LSB+ROUTE_W-1:C_ROUTE_LSB] = ROUTE;
   end

   assign cmp_rd = cmp_q;
   assign int_en = int_en_q;
endmodule

// File: rtl/evt_irq_route.sv
`timescale 1ns/1ps
module evt_irq_route #(
   parameter int NUM_CH = 3,
   parameter bit LEG_OK = 1'b1
) (
   input  logic [NUM_CH-1:0] status,
   input  logic [NUM_CH-1:0] int_en,
   input  logic              legacy,
   output logic [NUM_CH-1:0] irq_ch,
   output logic              irq_tmr,
   output logic              irq_rtc
);
   logic [NUM_CH-1:0] live;
   assign live = status & int_en;

   if (LEG_OK) begin : g_leg
      always_comb begin
         irq_ch  = live;
         irq_tmr = 1'b0;
         irq_rtc = 1'b0;
         if (legacy) begin
            irq_tmr     = live[0];
            irq_rtc     = live[1];
            irq_ch[1:0] = 2'b00;
         end
      end
   end else begin : g_plain
      assign irq_ch  = live;
      assign irq_tmr = 1'b0;
      assign irq_rtc = 1'b0;
   end
endmodule

// File: rtl/evt_regif.sv
`timescale 1ns/1ps
module evt_regif
   import evt_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 64
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic                   rd_en,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [31:0]            cap_word,
   input  logic [31:0]            period_word,
   input  logic [31:0]            gcfg_word,
   input  logic [31:0]            status_word,
   input  logic [CNT_W-1:0]       cnt,
   input  logic [NUM_CH-1:0][31:0] ch_cfg_rd,
   input  logic [NUM_CH-1:0][31:0] ch_cmp_rd,
   output logic                   gcfg_we,
   output logic                   status_we,
   output logic                   cnt_lo_we,
   output logic                   cnt_hi_we,
   output logic [NUM_CH-1:0]      ch_cfg_we,
   output logic [NUM_CH-1:0]      ch_cmp_we,
   output logic [31:0]            rdata
);
   localparam int HI_W = CNT_W - 32;

   logic [31:0] rd_mux;
   logic [31:0] cnt_hi_word;

   always_comb begin
      cnt_hi_word           = '0;
      cnt_hi_word[HI_W-1:0] = cnt[CNT_W-1:32];
   end

   assign gcfg_we   = wr_en && (addr == A_GCFG);
   assign status_we = wr_en && (addr == A_STATUS);
   assign cnt_lo_we = wr_en && (addr == A_CNT_LO);
   assign cnt_hi_we = wr_en && (addr == A_CNT_HI);

   for (genvar n = 0; n < NUM_CH; n++) begin : g_dec
      assign ch_cfg_we[n] = wr_en && (addr == ch_cfg_addr(n));
      assign ch_cmp_we[n] = wr_en && (addr == ch_cmp_addr(n));
   end

   always_comb begin
      rd_mux = '0;
      case (addr)
         A_CAP:    rd_mux = cap_word;
         A_PERIOD: rd_mux = period_word;
         A_GCFG:   rd_mux = gcfg_word;
         A_STATUS: rd_mux = status_word;
         A_CNT_LO: rd_mux = cnt[31:0];
         A_CNT_HI: rd_mux = cnt_hi_word;
         default:  rd_mux = '0;
      endcase
      for (int n = 0; n < NUM_CH; n++) begin
         if (addr == ch_cfg_addr(n)) rd_mux = ch_cfg_rd[n];
         if (addr == ch_cmp_addr(n)) rd_mux = ch_cmp_rd[n];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_en) begin
         rdata <= rd_mux;
      end
   end
endmodule

// File: rtl/evt_timer.sv
`timescale 1ns/1ps
module evt_timer
   import evt_pkg::*;
#(
   parameter int          NUM_CH        = 3,
   parameter int          CNT_W         = 64,
   parameter logic [31:0] PERIOD_FS     = 32'd41_666_667,
   parameter bit          LEG_OK        = 1'b1,
   parameter logic [31:0] PERIODIC_MASK = 32'hFFFF_FFFD,
   parameter int          ROUTE_BASE    = 20,
   parameter logic [7:0]  REV           = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [11:0]       addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic [NUM_CH-1:0] irq_ch,
   output logic              irq_legacy_tmr,
   output logic              irq_legacy_rtc
);
   localparam logic [31:0] CAP_WORD = 32'(REV)
                                    | (32'(NUM_CH - 1) << CAP_NCH_LSB)
                                    | (32'(CNT_W == 64) << CAP_W64)
                                    | (32'(LEG_OK) << CAP_LEG);

   if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_nch
      $error("evt_timer: NUM_CH must lie in 1..32");
   end
   if (CNT_W <= 32 || CNT_W > 64) begin : g_bad_cntw
      $error("evt_timer: CNT_W must lie in 33..64");
   end
   if (PERIOD_FS < MIN_PERIOD_FS || PERIOD_FS > MAX_PERIOD_FS) begin : g_bad_period
      $error("evt_timer: PERIOD_FS outside the sane range");
   end
   if (LEG_OK && NUM_CH < 2) begin : g_bad_leg
      $error("evt_timer: legacy routing needs two channels");
   end
   if (ROUTE_BASE + NUM_CH > 32) begin : g_bad_route
      $error("evt_timer: route numbers exceed the route field");
   end

   logic              run_q;
   logic              legacy_q;
   logic [NUM_CH-1:0] status_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [31:0]       gcfg_word;
   logic [31:0]       status_word;

   logic              gcfg_we, status_we, cnt_lo_we, cnt_hi_we;
   logic [NUM_CH-1:0] ch_cfg_we, ch_cmp_we;
   logic [NUM_CH-1:0][31:0] ch_cfg_rd, ch_cmp_rd;
   logic [NUM_CH-1:0] ch_match, ch_int_en;
   logic [NUM_CH-1:0] clr_bits;

   always_comb begin
      gcfg_word        = '0;
      gcfg_word[G_RUN] = run_q;
      gcfg_word[G_LEG] = legacy_q;
      status_word              = '0;
      status_word[NUM_CH-1:0]  = status_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         legacy_q <= 1'b0;
      end else if (gcfg_we) begin
         run_q    <= wdata[G_RUN];
         legacy_q <= LEG_OK ? wdata[G_LEG] : 1'b0;
      end
   end

   assign clr_bits = status_we ? wdata[NUM_CH-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
      end else begin
         status_q <= (status_q & ~clr_bits) | ch_match;
      end
   end

   evt_regif #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_regif (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .rd_en       (rd_en),
      .addr        (addr),
      .cap_word    (CAP_WORD),
      .period_word (PERIOD_FS),
      .gcfg_word   (gcfg_word),
      .status_word (status_word),
      .cnt         (cnt_q),
      .ch_cfg_rd   (ch_cfg_rd),
      .ch_cmp_rd   (ch_cmp_rd),
      .gcfg_we     (gcfg_we),
      .status_we   (status_we),
      .cnt_lo_we   (cnt_lo_we),
      .cnt_hi_we   (cnt_hi_we),
      .ch_cfg_we   (ch_cfg_we),
      .ch_cmp_we   (ch_cmp_we),
      .rdata       (rdata)
   );

   evt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_q),
      .wr_lo (cnt_lo_we),
      .wr_hi (cnt_hi_we),
      .wdata (wdata),
      .cnt   (cnt_q)
   );

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      evt_channel #(
         .PERIODIC_OK (PERIODIC_MASK[n]),
         .ROUTE       (ROUTE_W'(ROUTE_BASE + n))
      ) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .run    (run_q),
         .cfg_we (ch_cfg_we[n]),
         .cmp_we (ch_cmp_we[n]),
         .wdata  (wdata),
         .cnt_lo (cnt_q[31:0]),
         .cfg_rd (ch_cfg_rd[n]),
         .cmp_rd (ch_cmp_rd[n]),
         .match  (ch_match[n]),
         .int_en (ch_int_en[n])
      );
   end

   evt_irq_route #(.NUM_CH(NUM_CH), .LEG_OK(LEG_OK)) u_route (
      .status  (status_q),
      .int_en  (ch_int_en),
      .legacy  (legacy_q),
      .irq_ch  (irq_ch),
      .irq_tmr (irq_legacy_tmr),
      .irq_rtc (irq_legacy_rtc)
   );
endmodule

// File: rtl/evt_timer_chk.sv
`timescale 1ns/1ps
module evt_timer_chk
   import evt_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [11:0]       addr,
   input logic [NUM_CH-1:0] clr_data,
   input logic [NUM_CH-1:0] irq_ch,
   input logic              run_q,
   input logic              legacy_q,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [NUM_CH-1:0] status_q
);
   logic [NUM_CH-1:0] clr_mask;
   logic              cnt_touch;
   logic [NUM_CH-1:0] keep;

   assign clr_mask  = (wr_en && addr == A_STATUS) ? clr_data : '0;
   assign cnt_touch = wr_en && (addr == A_CNT_LO || addr == A_CNT_HI);
   assign keep      = status_q & ~clr_mask;

   assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> cnt_q == $past(cnt_q) + 1'b1);

   assert_halt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !cnt_touch) |=> $stable(cnt_q));

   assert_level_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (keep != '0) |=> ((status_q & $past(keep)) == $past(keep)));

   assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !legacy_q |-> ((irq_ch & ~status_q) == '0));

   assert_legacy_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
      legacy_q |-> (irq_ch[1:0] == 2'b00));
endmodule

bind evt_timer evt_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .clr_data (wdata[NUM_CH-1:0]),
   .irq_ch   (irq_ch),
   .run_q    (run_q),
   .legacy_q (legacy_q),
   .cnt_q    (cnt_q),
   .status_q (status_q)
);

// File: tb/sim_evt_timer.sv
`timescale 1ns/1ps
module sim_evt_timer;
   localparam int          NCH  = 3;
   localparam logic [31:0] PFS  = 32'd41_666_667;
   localparam int          RBAS = 20;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic            rd_en = 1'b0;
   logic [11:0]     addr = '0;
   logic [31:0]     wdata = '0;
   logic [31:0]     rdata;
   logic [NCH-1:0]  irq_ch;
   logic            irq_legacy_tmr;
   logic            irq_legacy_rtc;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   evt_timer u0 (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_en          (wr_en),
      .rd_en          (rd_en),
      .addr           (addr),
      .wdata          (wdata),
      .rdata          (rdata),
      .irq_ch         (irq_ch),
      .irq_legacy_tmr (irq_legacy_tmr),
      .irq_legacy_rtc (irq_legacy_rtc)
   );

   function automatic logic [11:0] cfg_a(input int n);
      return 12'(256 + 32 * n);
   endfunction
   function automatic logic [11:0] cmp_a(input int n);
      return 12'(256 + 32 * n + 8);
   endfunction
   function automatic logic [31:0] cfg_exp(input int n, input bit en, input bit per, input bit vs);
      logic [31:0] v;
      v = 32'(RBAS + n) << 9;
      v[5] = 1'b1;
      v[4] = (n != 1);
      v[3] = per;
      v[2] = en;
      v[6] = vs;
      return v;
   endfunction
   function automatic int fire_edge(input int delta);
      return delta + 1;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic set_cnt(input logic [31:0] hi, input logic [31:0] lo);
      wr(12'h010, 32'h0);
      wr(12'h0F0, lo);
      wr(12'h0F4, hi);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      logic [31:0] d;
      int unsigned seed;
      seed = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq_ch", 64'(irq_ch), 64'd0);
      chk("R1 legacy lines", 64'({irq_legacy_tmr, irq_legacy_rtc}), 64'd0);
      rd(12'h0F0, d); chk("R1 counter lo", 64'(d), 64'd0);
      rd(12'h0F4, d); chk("R1 counter hi", 64'(d), 64'd0);
      rd(12'h020, d); chk("R1 status", 64'(d), 64'd0);
      rd(12'h010, d); chk("R1 gcfg", 64'(d), 64'd0);

      // R2 capability and period
      rd(12'h000, d);
      chk("R2 capability", 64'(d), 64'(32'h01 | (32'(NCH - 1) << 8) | (32'd1 << 13) | (32'd1 << 15)));
      rd(12'h004, d); chk("R2 period", 64'(d), 64'(PFS));

      // R12 route and 32-bit flag, R8 capability flag
      for (int n = 0; n < NCH; n++) begin
         rd(cfg_a(n), d);
         chk("R12 R8 cfg reset", 64'(d), 64'(cfg_exp(n, 0, 0, 0)));
      end

      // R8 channel 1 periodic and arm bits ignored
      wr(cfg_a(1), 32'h4C);
      rd(cfg_a(1), d); chk("R8 ch1 cfg", 64'(d), 64'(cfg_exp(1, 1, 0, 0)));
      wr(cfg_a(1), 32'h0);

      // R3 counter load, count with carry, writes ignored while running
      set_cnt(32'h12, 32'hFFFF_FFF0);
      rd(12'h0F0, d); chk("R3 load lo", 64'(d), 64'hFFFF_FFF0);
      rd(12'h0F4, d); chk("R3 load hi", 64'(d), 64'h12);
      wr(12'h010, 32'h1);
      repeat (30) @(negedge clk);
      wr(12'h010, 32'h0);
      rd(12'h0F0, d); chk("R3 carry lo", 64'(d), 64'h0000_000F);
      rd(12'h0F4, d); chk("R3 carry hi", 64'(d), 64'h13);
      wr(12'h010, 32'h1);
      wr(12'h0F0, 32'h0);
      wr(12'h0F4, 32'h0);
      wr(12'h010, 32'h0);
      rd(12'h0F0, d); chk("R3 running write ignored lo", 64'(d), 64'h12);
      rd(12'h0F4, d); chk("R3 running write ignored hi", 64'(d), 64'h13);

      // R6 R7 periodic arm sequence
      set_cnt(32'h0, 32'h0);
      wr(12'h020, 32'h7);
      wr(cfg_a(0), 32'h4C);
      rd(cfg_a(0), d); chk("R7 arm pending", 64'(d), 64'(cfg_exp(0, 1, 1, 1)));
      wr(cmp_a(0), 32'd20);
      rd(cfg_a(0), d); chk("R7 arm still pending", 64'(d), 64'(cfg_exp(0, 1, 1, 1)));
      wr(cmp_a(0), 32'd10);
      rd(cfg_a(0), d); chk("R7 arm self-clear", 64'(d), 64'(cfg_exp(0, 1, 1, 0)));
      rd(cmp_a(0), d); chk("R6 first write is target", 64'(d), 64'd20);
      wr(12'h010, 32'h1);
      repeat (20) @(negedge clk);
      chk("R6 before first match", 64'(irq_ch[0]), 64'd0);
      @(negedge clk);
      chk("R6 first match", 64'(irq_ch[0]), 64'd1);
      wr(12'h020, 32'h1);
      chk("R10 clear drops level", 64'(irq_ch[0]), 64'd0);
      repeat (8) @(negedge clk);
      chk("R6 before reload match", 64'(irq_ch[0]), 64'd0);
      @(negedge clk);
      chk("R6 reload match", 64'(irq_ch[0]), 64'd1);
      repeat (5) @(negedge clk);
      chk("R10 level held", 64'(irq_ch[0]), 64'd1);
      rd(cmp_a(0), d); chk("R6 comparator advanced", 64'(d), 64'd40);
      wr(12'h010, 32'h0);
      wr(12'h020, 32'h7);
      wr(cfg_a(0), 32'h0);

      // R11 legacy routing
      set_cnt(32'h0, 32'h0);
      wr(cfg_a(0), 32'h4); wr(cmp_a(0), 32'd5);
      wr(cfg_a(1), 32'h4); wr(cmp_a(1), 32'd8);
      wr(12'h010, 32'h3);
      repeat (6) @(negedge clk);
      chk("R11 timer line", 64'(irq_legacy_tmr), 64'd1);
      chk("R11 ch0 masked", 64'(irq_ch[0]), 64'd0);
      repeat (3) @(negedge clk);
      chk("R11 alarm line", 64'(irq_legacy_rtc), 64'd1);
      chk("R11 ch1 masked", 64'(irq_ch[1]), 64'd0);
      wr(12'h010, 32'h1);
      chk("R11 normal routing back", 64'(irq_ch[1:0]), 64'd3);
      chk("R11 legacy lines idle", 64'({irq_legacy_tmr, irq_legacy_rtc}), 64'd0);
      wr(12'h010, 32'h0);
      wr(12'h020, 32'h7);
      chk("R10 all cleared", 64'(irq_ch), 64'd0);
      wr(cfg_a(0), 32'h0); wr(cfg_a(1), 32'h0);

      // R9 enable gate
      set_cnt(32'h0, 32'h0);
      wr(12'h020, 32'h7);
      wr(cfg_a(2), 32'h0); wr(cmp_a(2), 32'd4);
      wr(12'h010, 32'h1);
      repeat (10) @(negedge clk);
      chk("R9 gated output low", 64'(irq_ch[2]), 64'd0);
      rd(12'h020, d); chk("R9 status still set", 64'(d[2]), 64'd1);
      wr(cfg_a(2), 32'h4);
      chk("R9 gate opened", 64'(irq_ch[2]), 64'd1);
      wr(12'h010, 32'h0);
      wr(12'h020, 32'h7);
      chk("R10 gate cleared", 64'(irq_ch[2]), 64'd0);
      wr(cfg_a(2), 32'h0);

      // R5 target behind the counter
      set_cnt(32'h0, 32'd1000);
      wr(12'h020, 32'h7);
      wr(cfg_a(0), 32'h4); wr(cmp_a(0), 32'd995);
      wr(12'h010, 32'h1);
      repeat (40) @(negedge clk);
      chk("R5 past target silent", 64'(irq_ch[0]), 64'd0);
      rd(12'h020, d); chk("R5 past target status", 64'(d[0]), 64'd0);

      // R4 one-shot fires once
      set_cnt(32'h0, 32'h0);
      wr(12'h020, 32'h7);
      wr(cmp_a(0), 32'd3);
      wr(12'h010, 32'h1);
      repeat (4) @(negedge clk);
      chk("R4 one-shot fires", 64'(irq_ch[0]), 64'd1);
      wr(12'h020, 32'h1);
      repeat (50) @(negedge clk);
      rd(12'h020, d); chk("R4 no second fire", 64'(d[0]), 64'd0);
      wr(12'h010, 32'h0);
      wr(cfg_a(0), 32'h0);

      // R4 random one-shot targets
      for (int it = 0; it < 10; it++) begin
         int unsigned ch;
         int unsigned base;
         int unsigned delta;
         ch    = $urandom % NCH;
         base  = $urandom & 32'h7FFF_FFFF;
         delta = 5 + ($urandom % 60);
         set_cnt(32'h0, base);
         wr(12'h020, 32'h7);
         wr(cfg_a(int'(ch)), 32'h4);
         wr(cmp_a(int'(ch)), base + delta);
         wr(12'h010, 32'h1);
         repeat (fire_edge(int'(delta)) - 1) @(negedge clk);
         chk("R4 random before edge", 64'(irq_ch[ch]), 64'd0);
         @(negedge clk);
         chk("R4 random on edge", 64'(irq_ch[ch]), 64'd1);
         wr(12'h010, 32'h0);
         wr(12'h020, 32'h7);
         wr(cfg_a(int'(ch)), 32'h0);
      end

      done = 1'b1;
      finish_run();
   end
endmodule